// File: doc/BRIEF.md
# Tuner control register target on a two-wire serial bus

This block is the control-register end of a tuner device's serial interface. It sits on a two-wire bus as a target. SCL is an input only. SDA is an open-drain line: the block pulls it low through `sda_oe` and otherwise releases it. It holds a bank of 8-bit control registers, and one of those registers drives the device's standby mode.

A write frame names a starting register with a subaddress byte. The data bytes that follow fill that register and then the registers above it, one after another. Reads work differently. They carry no subaddress. Every read starts at register 00h and climbs until the controller answers a byte with NACK. A read address that arrives through a repeated START, with no STOP since the previous START, is not acknowledged.

One pin selects the least significant bit of the 7-bit device address, so that two such devices can share a bus. A local port lets the rest of the chip read and write the bank. The serial logic keeps running while the device is in standby, so a later write can bring the device out of it.

Top module: `tuner_ctl_i2c`

## Requirements
- R1: After reset, `sda_oe` is 0, `stby_o` is 0, `stby_mode_o` is 0 and every register reads 00h.
- R2: The device address is `{BASE_ADDR[6:1], addr_sel_i}`. The block acknowledges an address byte (7 address bits followed by a R/W bit, 1 = read) only when its address matches. After a mismatch it acknowledges no further byte and changes no register until the next START.
- R3: In a write frame, the byte after the address is the subaddress. The first data byte is stored in the register the subaddress names, and every written byte is acknowledged.
- R4: Each further data byte in the same frame goes to the next register. After the highest register (address NUM_REGS-1, 3Ah by default) the next byte goes to 00h.
- R5: A read returns 00h, 01h, 02h and so on in sequence while the controller acknowledges. A subaddress written earlier does not change the starting point.
- R6: After the controller NACKs a read byte, the block releases SDA and keeps it released until a new START.
- R7: A read address that follows a repeated START is not acknowledged. A write address after a repeated START is accepted. A read after a STOP and a fresh START is accepted.
- R8: Bits [1:0] of register STBY_ADDR (05h by default) form `stby_mode_o`. `stby_o` is high whenever that field is nonzero. Writes over the bus are still accepted while the device is in standby.
- R9: The local port writes a register on the clock edge where `loc_we_i` is high. `loc_rdata_o` shows the register at `loc_addr_i` combinationally. Both paths see the same storage as the bus.
- R10: A data byte whose subaddress is above NUM_REGS-1 is acknowledged and dropped. The byte after it goes to register 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| addr_sel_i | input | 1 | Device address LSB select |
| loc_we_i | input | 1 | Local register write enable |
| loc_addr_i | input | AW | Local register address |
| loc_wdata_i | input | 8 | Local write data |
| loc_rdata_o | output | 8 | Local read data |
| stby_mode_o | output | 2 | Standby mode field |
| stby_o | output | 1 | Standby active |

## Verification
The bench builds the block with its default parameters: BASE_ADDR 60h, 59 registers, standby field in register 05h and a two-stage synchronizer. With 59 registers, a three-byte burst starting at 39h crosses the wrap to 00h. A 19-byte read covers both the wrapped byte and a block written earlier at 10h. Both values of the address-select pin are used, so a frame sent to one address can be shown to be ignored while the other address is in effect.

// File: rtl/tuner_ctl_pkg.sv
package tuner_ctl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_TXACK
  } tgt_state_e;

  typedef enum logic [1:0] {
    BK_ADDR,
    BK_SUB,
    BK_DATA
  } byte_kind_e;
endpackage

// File: rtl/tuner_i2c_sync.sv
module tuner_i2c_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_pipe;
  logic [SYNC_STAGES-1:0] sda_pipe;
  logic scl_d, sda_d;

  // both lines start high (bus idle) so no edge is seen out of reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[SYNC_STAGES-1];
      sda_d    <= sda_pipe[SYNC_STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[SYNC_STAGES-1];
  assign sda_s     = sda_pipe[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  // an SDA edge while SCL stays high marks a bus condition
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/tuner_i2c_fsm.sv
module tuner_i2c_fsm
  import tuner_ctl_pkg::*;
#(
  parameter logic [6:0] BASE_ADDR = 7'h60,
  parameter int         NUM_REGS  = 59
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       sda_s,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic       addr_sel,
  input  logic [7:0] rd_data,
  output logic [7:0] ptr,
  output logic       sda_oe,
  output logic       wr_en,
  output logic [7:0] wr_data,
  output logic       idle
);
  localparam logic [7:0] LAST_A = 8'(NUM_REGS - 1);

  tgt_state_e state_q, state_n;
  byte_kind_e kind_q, kind_n;
  logic [3:0] cnt_q, cnt_n;
  logic [7:0] sh_q, sh_n;
  logic [7:0] ptr_q, ptr_n;
  logic       oe_q, oe_n;
  logic       seen_q, seen_n;
  logic       to_tx_q, to_tx_n;
  logic       busy_q, busy_n;
  logic       rep_q, rep_n;
  logic [6:0] dev_addr;
  logic [7:0] ptr_inc;

  assign dev_addr = {BASE_ADDR[6:1], addr_sel};
  assign ptr_inc  = (ptr_q >= LAST_A) ? 8'd0 : ptr_q + 8'd1;

  always_comb begin
    state_n = state_q;
    kind_n  = kind_q;
    cnt_n   = cnt_q;
    sh_n    = sh_q;
    ptr_n   = ptr_q;
    oe_n    = oe_q;
    seen_n  = seen_q;
    to_tx_n = to_tx_q;
    busy_n  = busy_q;
    rep_n   = rep_q;
    wr_en   = 1'b0;
    if (start_det) begin
      state_n = ST_RX;
      kind_n  = BK_ADDR;
      cnt_n   = 4'd0;
      oe_n    = 1'b0;
      seen_n  = 1'b0;
      rep_n   = busy_q;   // START with no STOP since the last one
      busy_n  = 1'b1;
    end else if (stop_det) begin
      state_n = ST_IDLE;
      oe_n    = 1'b0;
      seen_n  = 1'b0;
      busy_n  = 1'b0;
      rep_n   = 1'b0;
    end else begin
      unique case (state_q)
        ST_RX: begin
          if (scl_rise) begin
            sh_n  = {sh_q[6:0], sda_s};
            cnt_n = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            cnt_n = 4'd0;
            unique case (kind_q)
              BK_ADDR: begin
                if (sh_q[7:1] == dev_addr && !(sh_q[0] && rep_q)) begin
                  state_n = ST_ACK;
                  oe_n    = 1'b1;
                  to_tx_n = sh_q[0];
                  kind_n  = BK_SUB;
                  if (sh_q[0]) ptr_n = 8'd0;  // reads always begin at 00h
                end else begin
                  state_n = ST_IDLE;
                end
              end
              BK_SUB: begin
                ptr_n   = sh_q;
                state_n = ST_ACK;
                oe_n    = 1'b1;
                kind_n  = BK_DATA;
              end
              default: begin
                wr_en   = (ptr_q <= LAST_A);
                ptr_n   = ptr_inc;
                state_n = ST_ACK;
                oe_n    = 1'b1;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_rise) begin
            seen_n = 1'b1;
          end else if (scl_fall && seen_q) begin
            seen_n = 1'b0;
            cnt_n  = 4'd0;
            if (to_tx_q) begin
              state_n = ST_TX;
              sh_n    = rd_data;
              oe_n    = ~rd_data[7];
              ptr_n   = ptr_inc;
            end else begin
              state_n = ST_RX;
              oe_n    = 1'b0;
            end
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            cnt_n = cnt_q + 4'd1;
          end else if (scl_fall) begin
            if (cnt_q == 4'd8) begin
              oe_n    = 1'b0;
              state_n = ST_TXACK;
              cnt_n   = 4'd0;
            end else begin
              sh_n = {sh_q[6:0], 1'b0};
              oe_n = ~sh_q[6];
            end
          end
        end
        ST_TXACK: begin
          if (scl_rise) begin
            if (!sda_s) seen_n = 1'b1;
            else        state_n = ST_IDLE;  // NACK ends the read
          end else if (scl_fall && seen_q) begin
            seen_n  = 1'b0;
            sh_n    = rd_data;
            oe_n    = ~rd_data[7];
            ptr_n   = ptr_inc;
            state_n = ST_TX;
            cnt_n   = 4'd0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= BK_ADDR;
      cnt_q   <= 4'd0;
      sh_q    <= 8'd0;
      ptr_q   <= 8'd0;
      oe_q    <= 1'b0;
      seen_q  <= 1'b0;
      to_tx_q <= 1'b0;
      busy_q  <= 1'b0;
      rep_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      kind_q  <= kind_n;
      cnt_q   <= cnt_n;
      sh_q    <= sh_n;
      ptr_q   <= ptr_n;
      oe_q    <= oe_n;
      seen_q  <= seen_n;
      to_tx_q <= to_tx_n;
      busy_q  <= busy_n;
      rep_q   <= rep_n;
    end
  end

  assign ptr     = ptr_q;
  assign sda_oe  = oe_q;
  assign wr_data = sh_q;
  assign idle    = (state_q == ST_IDLE);
endmodule

// File: rtl/tuner_regbank.sv
module tuner_regbank #(
  parameter int NUM_REGS  = 59,
  parameter int AW        = 6,
  parameter int STBY_ADDR = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [7:0]    bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic          loc_we,
  input  logic [AW-1:0] loc_addr,
  input  logic [7:0]    loc_wdata,
  output logic [7:0]    loc_rdata,
  output logic [1:0]    stby_mode
);
  localparam logic [7:0] LAST_A = 8'(NUM_REGS - 1);

  logic [7:0] regs_w [NUM_REGS];
  logic [7:0] loc_addr8;

  assign loc_addr8 = 8'(loc_addr);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [7:0] val_q;
    logic       hit_bus, hit_loc;
    assign hit_bus = bus_we && (bus_addr == 8'(i));
    assign hit_loc = loc_we && (loc_addr == AW'(i));
    // bus write takes precedence over a local write to the same register
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       val_q <= 8'd0;
      else if (hit_bus) val_q <= bus_wdata;
      else if (hit_loc) val_q <= loc_wdata;
    end
    assign regs_w[i] = val_q;
  end

  assign bus_rdata = (bus_addr <= LAST_A) ? regs_w[bus_addr[AW-1:0]] : 8'd0;
  assign loc_rdata = (loc_addr8 <= LAST_A) ? regs_w[loc_addr] : 8'd0;
  assign stby_mode = regs_w[STBY_ADDR][1:0];
endmodule

// File: rtl/tuner_ctl_i2c.sv
module tuner_ctl_i2c #(
  parameter logic [6:0] BASE_ADDR   = 7'h60,
  parameter int         NUM_REGS    = 59,
  parameter int         STBY_ADDR   = 5,
  parameter int         SYNC_STAGES = 2,
  localparam int        AW          = $clog2(NUM_REGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic          addr_sel_i,
  input  logic          loc_we_i,
  input  logic [AW-1:0] loc_addr_i,
  input  logic [7:0]    loc_wdata_i,
  output logic [7:0]    loc_rdata_o,
  output logic [1:0]    stby_mode_o,
  output logic          stby_o
);
  logic [1:0] rst_pipe;
  logic       rst_n_sync;
  logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [7:0] ptr, rd_data, wr_data;
  logic       wr_en, fsm_idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_sync = rst_pipe[1];

  tuner_i2c_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n_sync), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  tuner_i2c_fsm #(.BASE_ADDR(BASE_ADDR), .NUM_REGS(NUM_REGS)) u_fsm (
    .clk(clk), .rst_n(rst_n_sync), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_s(sda_s), .start_det(start_det), .stop_det(stop_det),
    .addr_sel(addr_sel_i), .rd_data(rd_data), .ptr(ptr), .sda_oe(sda_oe),
    .wr_en(wr_en), .wr_data(wr_data), .idle(fsm_idle)
  );

  tuner_regbank #(.NUM_REGS(NUM_REGS), .AW(AW), .STBY_ADDR(STBY_ADDR)) u_bank (
    .clk(clk), .rst_n(rst_n_sync),
    .bus_we(wr_en), .bus_addr(ptr), .bus_wdata(wr_data), .bus_rdata(rd_data),
    .loc_we(loc_we_i), .loc_addr(loc_addr_i), .loc_wdata(loc_wdata_i),
    .loc_rdata(loc_rdata_o), .stby_mode(stby_mode_o)
  );

  assign stby_o = |stby_mode_o;
endmodule

// File: rtl/tuner_ctl_i2c_chk.sv
module tuner_ctl_i2c_chk #(
  parameter int NUM_REGS = 59
) (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       start_det,
  input logic       stop_det,
  input logic       sda_oe,
  input logic       fsm_idle,
  input logic       wr_en,
  input logic [7:0] ptr,
  input logic       loc_we,
  input logic [1:0] stby_mode
);
  localparam logic [7:0] LAST_A = 8'(NUM_REGS - 1);

  p_idle_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fsm_idle |-> !sda_oe);

  p_oe_moves_scl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> (!$past(scl_s) || $past(start_det) || $past(stop_det)));

  p_write_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !scl_s);

  p_write_in_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (ptr <= LAST_A));

  p_stby_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en) && !$past(loc_we)) |-> $stable(stby_mode));

  p_cond_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_det, stop_det}));
endmodule

bind tuner_ctl_i2c tuner_ctl_i2c_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n_sync), .scl_s(scl_s), .start_det(start_det),
  .stop_det(stop_det), .sda_oe(sda_oe), .fsm_idle(fsm_idle), .wr_en(wr_en),
  .ptr(ptr), .loc_we(loc_we_i), .stby_mode(stby_mode_o)
);

// File: tb/tuner_ctl_i2c_tb.sv
module tuner_ctl_i2c_tb;
  localparam int Q = 5;
  localparam int NR = 59;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1, addr_sel = 1'b0;
  logic loc_we = 1'b0;
  logic [5:0] loc_addr = '0;
  logic [7:0] loc_wdata = '0;
  logic sda_oe, stby;
  logic [7:0] loc_rdata;
  logic [1:0] stby_mode;
  logic sda_bus;

  assign sda_bus = sda_m & ~sda_oe;
  always #5 clk = ~clk;

  tuner_ctl_i2c u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .addr_sel_i(addr_sel), .loc_we_i(loc_we), .loc_addr_i(loc_addr),
    .loc_wdata_i(loc_wdata), .loc_rdata_o(loc_rdata),
    .stby_mode_o(stby_mode), .stby_o(stby)
  );

  int n_chk = 0, n_bad = 0;
  logic [7:0] mdl [NR];
  int exp_v[$];
  string exp_t[$];
  int obs_v[$];

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // scoreboard monitor: compares each observed bus item with the queued expectation
  initial forever begin
    wait (obs_v.size() != 0);
    begin
      int a;
      int e;
      string t;
      a = obs_v.pop_front();
      e = exp_v.pop_front();
      t = exp_t.pop_front();
      chk(t, a, e);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl = 1'b1; cyc(Q);
    sda_m = 1'b0; cyc(Q);
    scl = 1'b0; cyc(Q);
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; cyc(Q);
    scl = 1'b1; cyc(Q);
    sda_m = 1'b0; cyc(Q);
    scl = 1'b0; cyc(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; cyc(Q);
    scl = 1'b1; cyc(Q);
    sda_m = 1'b1; cyc(Q);
  endtask

  task automatic bus_bit(input logic b, output logic s);
    sda_m = b; cyc(Q);
    scl = 1'b1; cyc(Q);
    s = sda_bus;
    scl = 1'b0; cyc(Q);
  endtask

  task automatic tx_byte(input logic [7:0] b, input int exp_ack, input string tag);
    logic s;
    exp_v.push_back(exp_ack); exp_t.push_back(tag);
    for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
    bus_bit(1'b1, s);
    obs_v.push_back(s ? 0 : 1);
  endtask

  task automatic rx_byte(input int exp, input string tag, input logic ack);
    logic s;
    logic [7:0] v;
    exp_v.push_back(exp); exp_t.push_back(tag);
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, s);
      v[i] = s;
    end
    bus_bit(~ack, s);
    obs_v.push_back(int'(v));
  endtask

  task automatic mdl_wr(inout int p, input logic [7:0] d);
    if (p <= NR - 1) mdl[p] = d;
    p = (p >= NR - 1) ? 0 : p + 1;
  endtask

  task automatic wr_frame(input logic [6:0] dev, input logic [7:0] sub, input int n,
                          input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2,
                          input int acked, input string tag);
    int p;
    logic [7:0] d [3];
    d[0] = d0; d[1] = d1; d[2] = d2;
    p = int'(sub);
    bus_start();
    tx_byte({dev, 1'b0}, acked, tag);
    tx_byte(sub, acked, tag);
    for (int i = 0; i < n; i++) begin
      tx_byte(d[i], acked, tag);
      if (acked != 0) mdl_wr(p, d[i]);
    end
    bus_stop();
  endtask

  task automatic rd_frame(input logic [6:0] dev, input int n, input string tag);
    bus_start();
    tx_byte({dev, 1'b1}, 1, tag);
    for (int i = 0; i < n; i++) rx_byte(int'(mdl[i % NR]), tag, i != n - 1);
    bus_stop();
  endtask

  task automatic lchk(input int a, input string tag);
    loc_addr = 6'(a);
    cyc(1);
    chk(tag, int'(loc_rdata), int'(mdl[a]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    for (int i = 0; i < NR; i++) mdl[i] = 8'h00;
    cyc(4);
    rst_n = 1'b1;
    cyc(4);
    // R1: reset state
    chk("R1 sda_oe", int'(sda_oe), 0);
    chk("R1 stby", int'(stby), 0);
    chk("R1 stby_mode", int'(stby_mode), 0);
    lchk(8'h10, "R1 reg10");
    lchk(8'h3A, "R1 reg3A");

    // R2/R3: matched address, burst at 10h
    wr_frame(7'h60, 8'h10, 3, 8'h11, 8'h22, 8'h33, 1, "R3 write ack");
    lchk(8'h10, "R3 first byte");
    lchk(8'h11, "R4 second byte");
    lchk(8'h12, "R4 third byte");

    // R4: wrap past 3Ah
    wr_frame(7'h60, 8'h39, 3, 8'hA1, 8'hA2, 8'hA3, 1, "R4 wrap ack");
    lchk(8'h3A, "R4 last reg");
    lchk(8'h00, "R4 wrapped to 00h");

    // R5: read starts at 00h although subaddress was 39h
    rd_frame(7'h60, 19, "R5 read data");
    chk("R6 released after stop", int'(sda_oe), 0);

    // R2: other address ignored
    wr_frame(7'h61, 8'h20, 1, 8'h55, 8'h0, 8'h0, 0, "R2 mismatch nack");
    lchk(8'h20, "R2 mismatch no write");

    // R2: address select pin moves the address
    addr_sel = 1'b1;
    wr_frame(7'h61, 8'h20, 1, 8'h77, 8'h0, 8'h0, 1, "R2 sel=1 ack");
    lchk(8'h20, "R2 sel=1 write");

    // R7: read after repeated start refused
    bus_start();
    tx_byte({7'h61, 1'b0}, 1, "R7 write addr");
    tx_byte(8'h05, 1, "R7 sub");
    bus_rstart();
    tx_byte({7'h61, 1'b1}, 0, "R7 rs read nack");
    chk("R7 sda released", int'(sda_oe), 0);
    bus_stop();
    // R7: write after repeated start accepted
    bus_start();
    tx_byte({7'h61, 1'b0}, 1, "R7 write addr");
    tx_byte(8'h30, 1, "R7 sub");
    bus_rstart();
    tx_byte({7'h61, 1'b0}, 1, "R7 rs write ack");
    tx_byte(8'h31, 1, "R7 rs sub");
    tx_byte(8'h5A, 1, "R7 rs data");
    bus_stop();
    mdl[8'h31] = 8'h5A;
    lchk(8'h31, "R7 rs write stored");

    // R8: standby on then wake over the bus
    wr_frame(7'h61, 8'h05, 1, 8'h02, 8'h0, 8'h0, 1, "R8 stby write");
    cyc(2);
    chk("R8 stby_o on", int'(stby), 1);
    chk("R8 mode", int'(stby_mode), 2);
    wr_frame(7'h61, 8'h05, 1, 8'h00, 8'h0, 8'h0, 1, "R8 wake write");
    cyc(2);
    chk("R8 stby_o off", int'(stby), 0);

    // R9: local write seen over the bus
    loc_addr = 6'h07; loc_wdata = 8'hC3; loc_we = 1'b1;
    cyc(1);
    loc_we = 1'b0;
    mdl[7] = 8'hC3;
    lchk(8'h07, "R9 local readback");
    // R6: after NACK the block stays released before the STOP
    bus_start();
    tx_byte({7'h61, 1'b1}, 1, "R9 read addr");
    for (int i = 0; i < 8; i++) rx_byte(int'(mdl[i]), "R9 read data", i != 7);
    sda_m = 1'b1;
    cyc(3 * Q);
    chk("R6 released after NACK", int'(sda_oe), 0);
    bus_stop();

    // R10: out-of-range subaddress drops a byte, next goes to 00h
    wr_frame(7'h61, 8'h50, 2, 8'hEE, 8'h44, 8'h0, 1, "R10 ack");
    lchk(8'h00, "R10 wrap to 00h");
    rd_frame(7'h61, 2, "R10 read back");

    cyc(20);
    summary();
  end
endmodule